// File: doc/BRIEF.md
# Oscillator Control and Status Register

This block is a 32-bit control word for the clock sources of a chip: an internal RC oscillator, an external crystal oscillator and a PLL. Software writes enable bits, a crystal pass-through bit, a clock-monitor enable and a 5-bit trim. The block reports a ready flag for each source and returns a factory calibration byte. The calibration byte is captured from an input during reset. The trim is added to it to form the adjust code that drives the RC oscillator.

Hardware changes several bits on its own. Standby entry turns off the PLL and the crystal. Standby exit, or a crystal failure while the crystal clocks the system, turns the RC oscillator back on. A ready flag rises only after its stable or lock input has been high for a settle count. After its enable is cleared, the flag stays up for a fixed number of source-clock ticks. When the clock monitor is armed and the crystal is ready, a crystal failure sets a sticky fault flag and sends a one-cycle NMI request. Everything runs in one clock domain with a synchronous active-low reset. The source-clock ticks arrive as enable pulses.

Top module: `osc_ctl_reg`

## Requirements
- R1: Reset leaves the read word at `(cal_in_i << 8) | 0x83`: RC enable (bit 0) = 1, RC ready (bit 1) = 1, trim (bits 7:3) = 16, everything else 0. The outputs are rc_en_o = 1 and xo_en_o = pll_en_o = xo_bypass_o = fault_o = nmi_o = 0.
- R2: A write updates RC enable (bit 0), trim (bits 7:3), crystal enable (bit 16), monitor enable (bit 19) and PLL enable (bit 24). A write has no effect on the ready flags (bits 1, 17, 25) or the calibration byte (bits 15:8), and reserved bits 2 and 23:20 always read 0. The calibration byte changes only during reset.
- R3: A write to the crystal pass-through bit (bit 18) takes effect only if the crystal enable was 0 before that write. Otherwise the bit keeps its value.
- R4: While a source is enabled, its ready flag (bit 1 RC, bit 17 crystal) rises on the SETTLE_CYCLES-th consecutive clock with the stable input high. It falls on the first clock with the stable input low.
- R5: After a source's enable is cleared, its ready flag stays 1 until OFF_TICKS tick pulses of that source have been seen, and falls on the last of them. Clocks without a tick do not advance the count.
- R6: The PLL ready flag (bit 25) is a one-clock-delayed copy of PLL enable AND PLL lock.
- R7: Standby entry clears the crystal and PLL enables on the next clock and overrides a write in the same cycle. The RC enable is not affected.
- R8: Standby exit, or a crystal failure while the crystal is the system clock, sets the RC enable on the next clock and overrides a write in the same cycle.
- R9: The fault flag is set only by a crystal failure while the monitor enable and the crystal ready flag are both 1. It stays set until the clear strobe. When set and clear arrive together, set wins.
- R10: The NMI request is high for exactly one clock: the first clock in which the fault flag reads 1.
- R11: The adjust code is the 9-bit sum calibration + trim, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_in_i | input | 8 | Calibration byte captured during reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read image |
| rc_stable_i | input | 1 | RC oscillator output is stable |
| xo_stable_i | input | 1 | Crystal oscillator output is stable |
| pll_locked_i | input | 1 | PLL is locked |
| rc_tick_i | input | 1 | One pulse per RC source cycle |
| xo_tick_i | input | 1 | One pulse per crystal source cycle |
| standby_enter_i | input | 1 | Standby entry strobe |
| standby_exit_i | input | 1 | Standby exit strobe |
| xo_fail_i | input | 1 | Crystal clock failure detected |
| sysclk_is_xo_i | input | 1 | System clock currently comes from the crystal |
| fault_clr_i | input | 1 | Clears the sticky fault flag |
| rc_en_o | output | 1 | RC oscillator enable |
| xo_en_o | output | 1 | Crystal oscillator enable |
| xo_bypass_o | output | 1 | Crystal pass-through (external clock) select |
| pll_en_o | output | 1 | PLL enable |
| adj_code_o | output | 9 | RC adjust code, calibration + trim |
| fault_o | output | 1 | Sticky clock-monitor fault flag |
| nmi_o | output | 1 | One-cycle NMI request |

## Verification
The bench builds the block with SETTLE_CYCLES = 3 and the default OFF_TICKS = 6. A short settle count makes every ready rise observable cycle by cycle: the flag is checked one clock before and on the clock it rises. Every turn-off count from 1 to 6 ticks is checked, with idle clocks in between. Trim is swept over all 32 values for three calibration bytes, including 0xFF, so the unwrapped sum reaches its top value of 286. The pass-through gate is swept over all eight combinations of prior enable, prior value and written value.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;

  localparam int CAL_W  = 8;
  localparam int TRIM_W = 5;
  localparam int ADJ_W  = CAL_W + 1;

  // bit positions in the 32-bit control word
  localparam int P_RC_EN   = 0;
  localparam int P_RC_RDY  = 1;
  localparam int P_TRIM    = 3;
  localparam int P_CAL     = 8;
  localparam int P_XO_EN   = 16;
  localparam int P_XO_RDY  = 17;
  localparam int P_BYPASS  = 18;
  localparam int P_MON_EN  = 19;
  localparam int P_PLL_EN  = 24;
  localparam int P_PLL_RDY = 25;

  localparam logic [TRIM_W-1:0] TRIM_RESET = TRIM_W'(16);

  typedef struct packed {
    logic              pll_rdy;
    logic              pll_en;
    logic              mon_en;
    logic              bypass;
    logic              xo_rdy;
    logic              xo_en;
    logic [CAL_W-1:0]  cal;
    logic [TRIM_W-1:0] trim;
    logic              rc_rdy;
    logic              rc_en;
  } osc_state_t;

  function automatic logic [ADJ_W-1:0] osc_adjust(input logic [CAL_W-1:0] cal,
                                                  input logic [TRIM_W-1:0] trim);
    return ADJ_W'(cal) + ADJ_W'(trim);
  endfunction

  function automatic logic [31:0] osc_pack(input osc_state_t s);
    logic [31:0] w;
    w                        = '0;
    w[P_RC_EN]               = s.rc_en;
    w[P_RC_RDY]              = s.rc_rdy;
    w[P_TRIM +: TRIM_W]      = s.trim;
    w[P_CAL +: CAL_W]        = s.cal;
    w[P_XO_EN]               = s.xo_en;
    w[P_XO_RDY]              = s.xo_rdy;
    w[P_BYPASS]              = s.bypass;
    w[P_MON_EN]              = s.mon_en;
    w[P_PLL_EN]              = s.pll_en;
    w[P_PLL_RDY]             = s.pll_rdy;
    return w;
  endfunction

endpackage

// File: rtl/osc_rdy_track.sv
module osc_rdy_track #(
  parameter int SETTLE    = 16,
  parameter int OFF_TICKS = 6,
  parameter bit RST_READY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic stable_i,
  input  logic tick_i,
  output logic rdy_o
);

  localparam int SET_W = $clog2(SETTLE + 1);
  localparam int OFF_W = $clog2(OFF_TICKS + 1);

  logic [SET_W-1:0] set_cnt;
  logic [OFF_W-1:0] off_cnt;
  logic             rdy_q;

  // named events for the checks below
  logic settle_done;
  logic off_done;
  assign settle_done = en_i && stable_i && !rdy_q && (set_cnt == SET_W'(SETTLE - 1));
  assign off_done    = !en_i && rdy_q && tick_i && (off_cnt == OFF_W'(OFF_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_cnt <= '0;
      off_cnt <= '0;
      rdy_q   <= RST_READY;
    end else if (en_i) begin
      off_cnt <= '0;
      if (!stable_i) begin
        rdy_q   <= 1'b0;
        set_cnt <= '0;
      end else if (!rdy_q) begin
        if (settle_done) begin
          rdy_q   <= 1'b1;
          set_cnt <= '0;
        end else begin
          set_cnt <= set_cnt + 1'b1;
        end
      end
    end else begin
      set_cnt <= '0;
      if (rdy_q && tick_i) begin
        if (off_done) begin
          rdy_q   <= 1'b0;
          off_cnt <= '0;
        end else begin
          off_cnt <= off_cnt + 1'b1;
        end
      end
    end
  end

  assign rdy_o = rdy_q;

  // R4
  rdy_rise_needs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> $past(en_i && stable_i));

  // R5
  rdy_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_q) |-> ($past(!en_i && tick_i) || $past(en_i && !stable_i)));

  // R5
  rdy_hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !tick_i && rdy_q) |=> rdy_q);

endmodule

// File: rtl/osc_fault_mon.sv
module osc_fault_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en_i,
  input  logic xo_rdy_i,
  input  logic xo_fail_i,
  input  logic clr_i,
  output logic fault_o,
  output logic nmi_o
);

  logic watching;
  logic fault_evt;
  logic fault_q;
  logic nmi_q;

  assign watching  = mon_en_i && xo_rdy_i;
  assign fault_evt = watching && xo_fail_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      nmi_q   <= 1'b0;
    end else begin
      if (fault_evt)  fault_q <= 1'b1;
      else if (clr_i) fault_q <= 1'b0;
      nmi_q <= fault_evt && !fault_q;
    end
  end

  assign fault_o = fault_q;
  assign nmi_o   = nmi_q;

  // R9
  fault_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(mon_en_i && xo_rdy_i && xo_fail_i));

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clr_i) |=> fault_q);

  // R10
  nmi_with_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |-> (fault_q && $rose(fault_q)));

  // R10
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |=> !nmi_q);

endmodule

// File: rtl/osc_ctl_reg.sv
module osc_ctl_reg
  import osc_ctl_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16,
  parameter int OFF_TICKS     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAL_W-1:0] cal_in_i,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  output logic [31:0]      rd_data_o,
  input  logic             rc_stable_i,
  input  logic             xo_stable_i,
  input  logic             pll_locked_i,
  input  logic             rc_tick_i,
  input  logic             xo_tick_i,
  input  logic             standby_enter_i,
  input  logic             standby_exit_i,
  input  logic             xo_fail_i,
  input  logic             sysclk_is_xo_i,
  input  logic             fault_clr_i,
  output logic             rc_en_o,
  output logic             xo_en_o,
  output logic             xo_bypass_o,
  output logic             pll_en_o,
  output logic [ADJ_W-1:0] adj_code_o,
  output logic             fault_o,
  output logic             nmi_o
);

  localparam int NSRC = 2;  // index 0: RC, index 1: crystal

  logic              rc_en_q, xo_en_q, pll_en_q, byp_q, mon_q, pll_rdy_q;
  logic [TRIM_W-1:0] trim_q;
  logic [CAL_W-1:0]  cal_q;

  // hardware-driven events
  logic rc_force;
  logic sb_clear;
  logic byp_wr_ok;
  assign rc_force  = standby_exit_i || (xo_fail_i && sysclk_is_xo_i);
  assign sb_clear  = standby_enter_i;
  assign byp_wr_ok = wr_en_i && !xo_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc_en_q  <= 1'b1;
      xo_en_q  <= 1'b0;
      pll_en_q <= 1'b0;
      byp_q    <= 1'b0;
      mon_q    <= 1'b0;
      trim_q   <= TRIM_RESET;
      cal_q    <= cal_in_i;
    end else begin
      if (rc_force)     rc_en_q <= 1'b1;
      else if (wr_en_i) rc_en_q <= wr_data_i[P_RC_EN];

      if (sb_clear)     xo_en_q <= 1'b0;
      else if (wr_en_i) xo_en_q <= wr_data_i[P_XO_EN];

      if (sb_clear)     pll_en_q <= 1'b0;
      else if (wr_en_i) pll_en_q <= wr_data_i[P_PLL_EN];

      if (byp_wr_ok)    byp_q <= wr_data_i[P_BYPASS];

      if (wr_en_i) begin
        mon_q  <= wr_data_i[P_MON_EN];
        trim_q <= wr_data_i[P_TRIM +: TRIM_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pll_rdy_q <= 1'b0;
    else        pll_rdy_q <= pll_en_q && pll_locked_i;
  end

  // ready trackers for the two oscillators
  logic [NSRC-1:0] trk_en, trk_stb, trk_tick, trk_rdy;
  assign trk_en   = {xo_en_q, rc_en_q};
  assign trk_stb  = {xo_stable_i, rc_stable_i};
  assign trk_tick = {xo_tick_i, rc_tick_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_trk
    osc_rdy_track #(
      .SETTLE    (SETTLE_CYCLES),
      .OFF_TICKS (OFF_TICKS),
      .RST_READY (g == 0)
    ) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (trk_en[g]),
      .stable_i (trk_stb[g]),
      .tick_i   (trk_tick[g]),
      .rdy_o    (trk_rdy[g])
    );
  end

  osc_fault_mon u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_en_i  (mon_q),
    .xo_rdy_i  (trk_rdy[1]),
    .xo_fail_i (xo_fail_i),
    .clr_i     (fault_clr_i),
    .fault_o   (fault_o),
    .nmi_o     (nmi_o)
  );

  osc_state_t st;
  always_comb begin
    st.rc_en   = rc_en_q;
    st.rc_rdy  = trk_rdy[0];
    st.trim    = trim_q;
    st.cal     = cal_q;
    st.xo_en   = xo_en_q;
    st.xo_rdy  = trk_rdy[1];
    st.bypass  = byp_q;
    st.mon_en  = mon_q;
    st.pll_en  = pll_en_q;
    st.pll_rdy = pll_rdy_q;
  end

  assign rd_data_o   = osc_pack(st);
  assign rc_en_o     = rc_en_q;
  assign xo_en_o     = xo_en_q;
  assign xo_bypass_o = byp_q;
  assign pll_en_o    = pll_en_q;
  assign adj_code_o  = osc_adjust(cal_q, trim_q);

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data_i[31:25], wr_data_i[23:20], wr_data_i[17],
                            wr_data_i[15:8], wr_data_i[2:1]};

  // R3
  bypass_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xo_en_q |=> $stable(byp_q));

  // R7
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_enter_i |=> (!xo_en_q && !pll_en_q));

  // R8
  rc_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_exit_i || (xo_fail_i && sysclk_is_xo_i)) |=> rc_en_q);

  // R6
  pll_rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en_q && pll_locked_i) |=> pll_rdy_q);

  // R6
  pll_rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_locked_i |=> !pll_rdy_q);

  // R2
  cal_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cal_q));

endmodule

// File: tb/osc_ctl_reg_tb.sv
`timescale 1ns/1ps
module osc_ctl_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cal_in = 8'h00;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rc_stable = 1'b1, xo_stable = 1'b0, pll_locked = 1'b0;
  logic        rc_tick = 1'b0, xo_tick = 1'b0;
  logic        sb_enter = 1'b0, sb_exit = 1'b0, xo_fail = 1'b0, sys_xo = 1'b0, f_clr = 1'b0;
  logic        rc_en, xo_en, byp, pll_en, fault, nmi;
  logic [8:0]  adj;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  osc_ctl_reg #(.SETTLE_CYCLES(3), .OFF_TICKS(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .cal_in_i(cal_in), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .rc_stable_i(rc_stable), .xo_stable_i(xo_stable),
    .pll_locked_i(pll_locked), .rc_tick_i(rc_tick), .xo_tick_i(xo_tick),
    .standby_enter_i(sb_enter), .standby_exit_i(sb_exit), .xo_fail_i(xo_fail),
    .sysclk_is_xo_i(sys_xo), .fault_clr_i(f_clr), .rc_en_o(rc_en), .xo_en_o(xo_en),
    .xo_bypass_o(byp), .pll_en_o(pll_en), .adj_code_o(adj), .fault_o(fault), .nmi_o(nmi)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic [7:0] c);
    cal_in = c;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  task automatic pulse_rc_tick();
    rc_tick = 1'b1; step(); rc_tick = 1'b0; step();
  endtask

  task automatic pulse_xo_tick();
    xo_tick = 1'b1; step(); xo_tick = 1'b0; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    logic [7:0] cal;
    cal = 8'h00;
    step();
    // R1, R2, R11: reset image and full trim sweep for three calibration bytes
    for (int ci = 0; ci < 3; ci++) begin
      cal = (ci == 0) ? 8'h00 : (ci == 1) ? 8'h5A : 8'hFF;
      do_reset(cal);
      chk("R1 reset word", rd_data, (32'(cal) << 8) | 32'h83);
      chk("R1 reset outputs", {26'd0, rc_en, xo_en, pll_en, byp, fault, nmi}, 32'b100000);
      chk("R11 reset adjust", 32'(adj), 32'(cal) + 32'd16);
      cal_in = ~cal;
      step();
      chk("R2 cal frozen", 32'(rd_data[15:8]), 32'(cal));
      for (int t = 0; t < 32; t++) begin
        wr((32'(t) << 3) | 32'h1);
        chk("R2 trim field", 32'(rd_data[7:3]), 32'(t));
        chk("R11 adjust sum", 32'(adj), 32'(cal) + 32'(t));
      end
    end

    // R2: read-only and reserved bits ignore writes
    wr(32'h02F2_FF06);
    chk("R2 read-only ignored", rd_data, (32'(cal) << 8) | 32'h2);
    wr(32'h81);
    chk("R2 restore", rd_data, (32'(cal) << 8) | 32'h83);

    // R5: RC turn-off delay swept over tick counts, with idle clocks
    wr(32'h80);
    repeat (10) step();
    chk("R5 no tick no fall", 32'(rd_data[1]), 32'd1);
    for (int k = 1; k <= 6; k++) begin
      pulse_rc_tick();
      chk("R5 rc ready after ticks", 32'(rd_data[1]), (k < 6) ? 32'd1 : 32'd0);
    end
    chk("R2 rc enable cleared", 32'(rc_en), 32'd0);

    // R4: RC settle after re-enable
    wr(32'h81);
    step(); step();
    chk("R4 rc not yet ready", 32'(rd_data[1]), 32'd0);
    step();
    chk("R4 rc ready at settle", 32'(rd_data[1]), 32'd1);

    // R4: crystal settle, drop and re-settle
    wr(32'h0001_0081);
    repeat (5) step();
    chk("R4 xo unstable not ready", 32'(rd_data[17]), 32'd0);
    xo_stable = 1'b1;
    step(); step();
    chk("R4 xo before settle", 32'(rd_data[17]), 32'd0);
    step();
    chk("R4 xo at settle", 32'(rd_data[17]), 32'd1);
    xo_stable = 1'b0;
    step();
    chk("R4 xo drops on unstable", 32'(rd_data[17]), 32'd0);
    xo_stable = 1'b1;
    repeat (3) step();
    chk("R4 xo re-settled", 32'(rd_data[17]), 32'd1);

    // R9, R10: clock monitor
    xo_fail = 1'b1; step(); xo_fail = 1'b0;
    chk("R9 monitor off no fault", {30'd0, fault, nmi}, 32'd0);
    wr(32'h0009_0081);
    xo_fail = 1'b1; step(); xo_fail = 1'b0;
    chk("R10 fault and nmi", {30'd0, fault, nmi}, 32'b11);
    step();
    chk("R10 nmi single pulse", {30'd0, fault, nmi}, 32'b10);
    xo_fail = 1'b1; step(); xo_fail = 1'b0;
    chk("R10 no nmi while set", {30'd0, fault, nmi}, 32'b10);
    repeat (4) step();
    chk("R9 fault sticky", 32'(fault), 32'd1);
    f_clr = 1'b1; step(); f_clr = 1'b0;
    chk("R9 fault cleared", {30'd0, fault, nmi}, 32'd0);
    xo_fail = 1'b1; f_clr = 1'b1; step(); xo_fail = 1'b0; f_clr = 1'b0;
    chk("R9 set beats clear", {30'd0, fault, nmi}, 32'b11);
    f_clr = 1'b1; step(); f_clr = 1'b0;
    wr(32'h0008_0081);
    for (int k = 1; k <= 6; k++) begin
      pulse_xo_tick();
      chk("R5 xo ready after ticks", 32'(rd_data[17]), (k < 6) ? 32'd1 : 32'd0);
    end
    xo_fail = 1'b1; step(); xo_fail = 1'b0;
    chk("R9 xo not ready no fault", {30'd0, fault, nmi}, 32'd0);

    // R3: pass-through gate, all eight combinations
    for (int xo_old = 0; xo_old < 2; xo_old++) begin
      for (int b_old = 0; b_old < 2; b_old++) begin
        for (int b_new = 0; b_new < 2; b_new++) begin
          wr(32'h81);
          wr(32'h81);
          wr(32'h81 | (32'(b_old) << 18));
          if (xo_old == 1) wr(32'h0001_0081 | (32'(b_old) << 18));
          wr(32'h81 | (32'(xo_old) << 16) | (32'(b_new) << 18));
          chk("R3 bypass output", 32'(byp), (xo_old == 1) ? 32'(b_old) : 32'(b_new));
          chk("R3 bypass bit", 32'(rd_data[18]), (xo_old == 1) ? 32'(b_old) : 32'(b_new));
        end
      end
    end
    wr(32'h81);
    wr(32'h81);

    // R6: PLL ready
    pll_locked = 1'b1;
    step();
    chk("R6 lock without enable", 32'(rd_data[25]), 32'd0);
    wr(32'h0100_0081);
    chk("R6 pll enable out", 32'(pll_en), 32'd1);
    chk("R6 ready one clock late", 32'(rd_data[25]), 32'd0);
    step();
    chk("R6 ready follows", 32'(rd_data[25]), 32'd1);
    pll_locked = 1'b0;
    step();
    chk("R6 ready drops with lock", 32'(rd_data[25]), 32'd0);

    // R7: standby entry beats a same-cycle write
    wr(32'h0101_0081);
    sb_enter = 1'b1;
    wr(32'h0101_0081);
    sb_enter = 1'b0;
    chk("R7 enables cleared", {29'd0, xo_en, pll_en, rc_en}, 32'b001);
    chk("R7 read bits cleared", {30'd0, rd_data[24], rd_data[16]}, 32'd0);

    // R8: forced RC enable
    sb_exit = 1'b1;
    wr(32'h80);
    sb_exit = 1'b0;
    chk("R8 standby exit sets rc", 32'(rc_en), 32'd1);
    wr(32'h80);
    chk("R2 rc enable writable", 32'(rc_en), 32'd0);
    xo_fail = 1'b1; step(); xo_fail = 1'b0;
    chk("R8 fail not system clock", 32'(rc_en), 32'd0);
    sys_xo = 1'b1; xo_fail = 1'b1;
    wr(32'h80);
    sys_xo = 1'b0; xo_fail = 1'b0;
    chk("R8 fail on system clock", 32'(rc_en), 32'd1);

    finish_run();
  end

endmodule